// File: doc/BRIEF.md
# Dual-Output PWM Compare Operator

This block turns the count of an external PWM time base into two pulse-width modulated pin levels, A and B. Each output has its own 16-bit threshold. A clocked comparator drives its output active while the counter is below the active threshold. An up-counting ramp from zero therefore gives an edge-aligned pulse. An up-down ramp gives a pulse centred on the counter's zero point.

Thresholds are written into a shadow register. They move into the active register at a selectable point of the counting cycle. This lets software change the duty cycle without a glitch in the middle of a period. After the comparator, each output can be inverted. Software can also force each output to a fixed level. The force acts combinationally and does not wait for any count.

The time base is outside this block. It supplies the count and a one-cycle strobe at zero and another at its top count.

Top module: `pwm_dual_operator`

## Requirements
- R1: One clock after the counter shows value v, an output with inversion and force both off is high if v is below that output's active threshold, and low otherwise.
- R2: With the counter ramping 0..99 and a threshold of 50, the output is high for exactly 50 of the 100 counts. A threshold of 0 keeps it low for the whole period. A threshold above 99 keeps it high for the whole period.
- R3: With the counter ramping 0 up to 99 and back down to 1, a threshold of 30 makes the output high for 59 of the 198 counts. The output is low at the top count.
- R4: A threshold write (`ts_wr` bit 0 selects A, bit 1 selects B) reaches the active register according to `upd_sel`. 2'b00 loads it at the writing edge. 2'b01 loads it from the shadow at an edge where `cnt_zero` is high. 2'b10 does the same on `cnt_peak`. 2'b11 loads on either strobe. Without the selected event, the active threshold, and so the output, does not change.
- R5: With `out_inv` set for an output (bit 0 = A, bit 1 = B), its level is the complement of the compare result.
- R6: With `ovr_en` set for an output, the pin equals the matching `ovr_lvl` bit in the same cycle, whatever the compare result and the inversion.
- R7: A and B are independent. Threshold, inversion and force of one never change the other.
- R8: After reset, both active and shadow thresholds are 0. Both pins are low while inversion and force are off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cnt_val | input | 16 | Counter value from the time base |
| cnt_zero | input | 1 | Strobe: counter is at zero this cycle |
| cnt_peak | input | 1 | Strobe: counter is at its top count this cycle |
| upd_sel | input | 2 | Threshold load point (see R4) |
| ts_wdata | input | 16 | Threshold write data |
| ts_wr | input | 2 | Threshold write enables, bit 0 = A, bit 1 = B |
| out_inv | input | 2 | Invert compare result, bit 0 = A, bit 1 = B |
| ovr_en | input | 2 | Force enable, bit 0 = A, bit 1 = B |
| ovr_lvl | input | 2 | Forced level, bit 0 = A, bit 1 = B |
| pin_a | output | 1 | Output A level |
| pin_b | output | 1 | Output B level |

## Verification
A vector table sets single counter values around a threshold: one below, equal, zero and the top of the range. These vectors separate a strict less-than compare from an inclusive one, and show what inversion and the force do to that result. Full up ramps with thresholds of 0, 50 and above the period measure the duty cycle and the two saturated cases. An up-down ramp tells a level compare from one that is set and cleared on events. Shadow tests write a new threshold in each load mode and then withhold or supply the strobe, which shows whether the load waits for the chosen event. A final test gives A and B different settings, which would expose any crosstalk between the two outputs.

// File: rtl/pwm_op_pkg.sv
// Package: shared types for the dual-output PWM compare operator.
// Assumes: two outputs per operator; the load-point encoding is fixed.
package pwm_op_pkg;

    localparam int unsigned NUM_OUT = 2;

    typedef enum logic [1:0] {
        UPD_NOW  = 2'b00,
        UPD_ZERO = 2'b01,
        UPD_PEAK = 2'b10,
        UPD_BOTH = 2'b11
    } upd_sel_e;

endpackage

// File: rtl/pwm_ts_shadow.sv
// Module: shadow and active threshold pair for one output.
// What it does: captures writes into a shadow register, then moves the shadow
//   into the active register at the load point chosen by upd_sel. In UPD_NOW
//   mode a write goes into both registers at the same edge.
// Assumes: at_zero / at_peak are single-cycle strobes from the time base.
module pwm_ts_shadow
    import pwm_op_pkg::*;
#(
    parameter int unsigned CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  upd_sel_e      upd_sel,
    input  logic          at_zero,
    input  logic          at_peak,
    input  logic          wr_en,
    input  logic [CW-1:0] wr_data,
    output logic [CW-1:0] act_ts
);

    logic [CW-1:0] shadow_q;
    logic          load_evt;

    // Decide whether this cycle is a load point for the shadow value.
    always_comb begin
        unique case (upd_sel)
            UPD_ZERO: load_evt = at_zero;
            UPD_PEAK: load_evt = at_peak;
            UPD_BOTH: load_evt = at_zero | at_peak;
            default:  load_evt = 1'b0;
        endcase
    end

    // Capture software writes into the shadow register.
    always_ff @(posedge clk) begin
        if (!rst_n)     shadow_q <= '0;
        else if (wr_en) shadow_q <= wr_data;
    end

    // Update the active threshold: direct write, or shadow copy at a load point.
    always_ff @(posedge clk) begin
        if (!rst_n)                           act_ts <= '0;
        else if (upd_sel == UPD_NOW && wr_en) act_ts <= wr_data;
        else if (load_evt)                    act_ts <= shadow_q;
    end

endmodule

// File: rtl/pwm_cmp_stage.sv
// Module: registered threshold comparator for one output.
// What it does: cmp_q is high one cycle after the count is below the threshold.
// Assumes: count and threshold are unsigned and of the same width.
module pwm_cmp_stage #(
    parameter int unsigned CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] cnt,
    input  logic [CW-1:0] thr,
    output logic          cmp_q
);

    // Register the below-threshold result.
    always_ff @(posedge clk) begin
        if (!rst_n) cmp_q <= 1'b0;
        else        cmp_q <= (cnt < thr);
    end

endmodule

// File: rtl/pwm_out_stage.sv
// Module: polarity and force stage for one output.
// What it does: inverts the compare result if asked, then lets the force win.
// Assumes: the force controls are static or change slowly; the path is combinational.
module pwm_out_stage (
    input  logic cmp,
    input  logic inv,
    input  logic frc_en,
    input  logic frc_lvl,
    output logic pin
);

    logic pol;

    // Polarity first, then the software force on top.
    always_comb begin
        pol = cmp ^ inv;
        pin = frc_en ? frc_lvl : pol;
    end

endmodule

// File: rtl/pwm_dual_operator.sv
// Module: dual-output PWM compare operator (top).
// What it does: builds one threshold/compare/output chain per output from a
//   shared time-base count and shared write data.
// Assumes: the time base drives cnt_val, cnt_zero and cnt_peak in the same clock domain.
module pwm_dual_operator
    import pwm_op_pkg::*;
#(
    parameter int unsigned CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] cnt_val,
    input  logic          cnt_zero,
    input  logic          cnt_peak,
    input  logic [1:0]    upd_sel,
    input  logic [CW-1:0] ts_wdata,
    input  logic [1:0]    ts_wr,
    input  logic [1:0]    out_inv,
    input  logic [1:0]    ovr_en,
    input  logic [1:0]    ovr_lvl,
    output logic          pin_a,
    output logic          pin_b
);

    localparam int unsigned NCH = NUM_OUT;

    upd_sel_e      upd_e;
    logic [CW-1:0] act_ts [NCH];
    logic [NCH-1:0] cmp_w;
    logic [NCH-1:0] pin_w;

    // Turn the raw load-point field into the enum type.
    always_comb upd_e = upd_sel_e'(upd_sel);

    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        pwm_ts_shadow #(.CW(CW)) u_ts (
            .clk     (clk),
            .rst_n   (rst_n),
            .upd_sel (upd_e),
            .at_zero (cnt_zero),
            .at_peak (cnt_peak),
            .wr_en   (ts_wr[ch]),
            .wr_data (ts_wdata),
            .act_ts  (act_ts[ch])
        );

        pwm_cmp_stage #(.CW(CW)) u_cmp (
            .clk   (clk),
            .rst_n (rst_n),
            .cnt   (cnt_val),
            .thr   (act_ts[ch]),
            .cmp_q (cmp_w[ch])
        );

        pwm_out_stage u_out (
            .cmp     (cmp_w[ch]),
            .inv     (out_inv[ch]),
            .frc_en  (ovr_en[ch]),
            .frc_lvl (ovr_lvl[ch]),
            .pin     (pin_w[ch])
        );
    end

    // Bring the per-output levels to the named pins.
    always_comb begin
        pin_a = pin_w[0];
        pin_b = pin_w[1];
    end

endmodule

// File: rtl/pwm_dual_operator_chk.sv
// Module: property checker for pwm_dual_operator, bound to the top below.
// What it does: checks compare timing, shadow loading and force priority.
// Assumes: it sees the active thresholds of both outputs via the bind.
module pwm_dual_operator_chk #(
    parameter int unsigned CW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic [CW-1:0] cnt_val,
    input logic          cnt_zero,
    input logic [1:0]    upd_sel,
    input logic [CW-1:0] ts_wdata,
    input logic [1:0]    ts_wr,
    input logic [1:0]    out_inv,
    input logic [1:0]    ovr_en,
    input logic [1:0]    ovr_lvl,
    input logic          pin_a,
    input logic          pin_b,
    input logic [CW-1:0] act_a,
    input logic [CW-1:0] act_b
);

    AST_A_BELOW_TS: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_val < act_a) |=> (ovr_en[0] || (pin_a != out_inv[0]))); // R1
    AST_B_BELOW_TS: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_val < act_b) |=> (ovr_en[1] || (pin_b != out_inv[1]))); // R7
    AST_A_ZERO_TS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (act_a == '0) |=> (ovr_en[0] || (pin_a == out_inv[0]))); // R2
    AST_A_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_sel == 2'b01 && !cnt_zero) |=> $stable(act_a)); // R4
    AST_B_IMM_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_sel == 2'b00 && ts_wr[1]) |=> (act_b == $past(ts_wdata))); // R4
    AST_A_FORCE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_en[0] |-> (pin_a == ovr_lvl[0])); // R6
    AST_B_FORCE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_en[1] |-> (pin_b == ovr_lvl[1])); // R6

endmodule

bind pwm_dual_operator pwm_dual_operator_chk #(.CW(CW)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .cnt_val  (cnt_val),
    .cnt_zero (cnt_zero),
    .upd_sel  (upd_sel),
    .ts_wdata (ts_wdata),
    .ts_wr    (ts_wr),
    .out_inv  (out_inv),
    .ovr_en   (ovr_en),
    .ovr_lvl  (ovr_lvl),
    .pin_a    (pin_a),
    .pin_b    (pin_b),
    .act_a    (act_ts[0]),
    .act_b    (act_ts[1])
);

// File: tb/pwm_dual_operator_tb_top.sv
// Bench: vector table for compare/polarity/force, then directed tests for
// reset, ramps, shadow loading and output independence.
module pwm_dual_operator_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cnt_val = '0;
    logic        cnt_zero = 1'b0;
    logic        cnt_peak = 1'b0;
    logic [1:0]  upd_sel = 2'b00;
    logic [15:0] ts_wdata = '0;
    logic [1:0]  ts_wr = '0;
    logic [1:0]  out_inv = '0;
    logic [1:0]  ovr_en = '0;
    logic [1:0]  ovr_lvl = '0;
    logic        pin_a;
    logic        pin_b;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    pwm_dual_operator dut_i (
        .clk(clk), .rst_n(rst_n), .cnt_val(cnt_val), .cnt_zero(cnt_zero),
        .cnt_peak(cnt_peak), .upd_sel(upd_sel), .ts_wdata(ts_wdata),
        .ts_wr(ts_wr), .out_inv(out_inv), .ovr_en(ovr_en), .ovr_lvl(ovr_lvl),
        .pin_a(pin_a), .pin_b(pin_b)
    );

    // {threshold, count, inv, force_en, force_lvl, expected pin_a}
    localparam int NV = 10;
    localparam logic [35:0] VEC [NV] = '{
        {16'd50,    16'd49,    4'b0001},  // R1 below
        {16'd50,    16'd50,    4'b0000},  // R1 equal
        {16'd50,    16'd0,     4'b0001},  // R1 zero count
        {16'd0,     16'd0,     4'b0000},  // R2 zero threshold
        {16'd65535, 16'd65534, 4'b0001},  // R1 top of range
        {16'd50,    16'd10,    4'b1000},  // R5 inverted high
        {16'd50,    16'd60,    4'b1001},  // R5 inverted low
        {16'd50,    16'd10,    4'b0100},  // R6 force low
        {16'd50,    16'd60,    4'b0111},  // R6 force high
        {16'd50,    16'd60,    4'b1100}   // R6 force beats inversion
    };

    task automatic check(input logic got, input logic exp, input string tag);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0b expected %0b", tag, got, exp);
        end
    endtask

    task automatic check_int(input int got, input int exp, input string tag);
        n_run++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    // Immediate-mode write of a threshold into the outputs given by mask.
    task automatic load_now(input logic [1:0] mask, input logic [15:0] val);
        upd_sel  = 2'b00;
        ts_wdata = val;
        ts_wr    = mask;
        tick();
        ts_wr    = '0;
    endtask

    // Run two periods; count the high cycles of each pin in the second one.
    task automatic run_ramp(input bit updown, output int hi_a, output int hi_b);
        int len;
        len  = updown ? 198 : 100;
        hi_a = 0;
        hi_b = 0;
        for (int p = 0; p < 2; p++) begin
            for (int i = 0; i < len; i++) begin
                int c;
                c = (i < 100) ? i : 198 - i;
                cnt_val  = 16'(c);
                cnt_zero = (c == 0);
                cnt_peak = (c == 99);
                tick();
                if (p == 1) begin
                    hi_a += int'(pin_a);
                    hi_b += int'(pin_b);
                    if (updown && c == 99) check(pin_a, 1'b0, "R3 low at top count");
                end
            end
        end
        cnt_zero = 1'b0;
        cnt_peak = 1'b0;
    endtask

    initial begin
        int ha, hb;
        // R8: reset state
        repeat (3) tick();
        check(pin_a, 1'b0, "R8 pin_a in reset");
        rst_n = 1'b1;
        cnt_val = 16'd0;
        tick();
        tick();
        check(pin_a, 1'b0, "R8 pin_a after reset");
        check(pin_b, 1'b0, "R8 pin_b after reset");

        // Vector table on output A
        for (int v = 0; v < NV; v++) begin
            load_now(2'b01, VEC[v][35:20]);
            cnt_val = VEC[v][19:4];
            tick();
            out_inv[0] = VEC[v][3];
            ovr_en[0]  = VEC[v][2];
            ovr_lvl[0] = VEC[v][1];
            #1;
            check(pin_a, VEC[v][0], $sformatf("R1/R5/R6 vector %0d", v));
            out_inv = '0;
            ovr_en  = '0;
            ovr_lvl = '0;
        end

        // R2: up ramp duty and saturation
        load_now(2'b11, 16'd50);
        run_ramp(1'b0, ha, hb);
        check_int(ha, 50, "R2 duty threshold 50");
        load_now(2'b01, 16'd0);
        load_now(2'b10, 16'd120);
        run_ramp(1'b0, ha, hb);
        check_int(ha, 0, "R2 threshold 0 always low");
        check_int(hb, 100, "R2 threshold above period always high");

        // R3: up-down ramp
        load_now(2'b11, 16'd30);
        run_ramp(1'b1, ha, hb);
        check_int(ha, 59, "R3 centred pulse width");

        // R4: load at zero strobe
        load_now(2'b01, 16'd50);
        upd_sel  = 2'b01;
        ts_wdata = 16'd10;
        ts_wr    = 2'b01;
        cnt_val  = 16'd20;
        tick();
        ts_wr = '0;
        tick();
        check(pin_a, 1'b1, "R4 zero mode holds old threshold");
        cnt_zero = 1'b1;
        tick();
        cnt_zero = 1'b0;
        tick();
        check(pin_a, 1'b0, "R4 zero mode loads on strobe");

        // R4: load at top-count strobe
        upd_sel  = 2'b10;
        ts_wdata = 16'd40;
        ts_wr    = 2'b01;
        tick();
        ts_wr    = '0;
        cnt_zero = 1'b1;
        tick();
        cnt_zero = 1'b0;
        tick();
        check(pin_a, 1'b0, "R4 peak mode ignores zero strobe");
        cnt_peak = 1'b1;
        tick();
        cnt_peak = 1'b0;
        tick();
        check(pin_a, 1'b1, "R4 peak mode loads on strobe");

        // R4: either strobe
        upd_sel  = 2'b11;
        ts_wdata = 16'd5;
        ts_wr    = 2'b01;
        tick();
        ts_wr = '0;
        tick();
        check(pin_a, 1'b1, "R4 both mode waits for a strobe");
        cnt_zero = 1'b1;
        tick();
        cnt_zero = 1'b0;
        tick();
        check(pin_a, 1'b0, "R4 both mode loads on zero");

        // R7: independence of A and B
        load_now(2'b01, 16'd80);
        load_now(2'b10, 16'd20);
        cnt_val = 16'd50;
        tick();
        check(pin_a, 1'b1, "R7 A own threshold");
        check(pin_b, 1'b0, "R7 B own threshold");
        ovr_en[1]  = 1'b1;
        ovr_lvl[1] = 1'b1;
        out_inv[1] = 1'b1;
        #1;
        check(pin_b, 1'b1, "R7 B forced");
        check(pin_a, 1'b1, "R7 A unaffected by B controls");
        ovr_en  = '0;
        ovr_lvl = '0;
        out_inv = '0;

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule